// File: doc/BRIEF.md
# Debug Breakpoint and Halt-Entry Controller

This block decides, for a processor core, whether a breakpoint is taken and how the core enters its background debug halt state. Every memory access the core makes is marked as either an instruction prefetch or an operand access. A breakpoint request can arrive with any access, from the external breakpoint pin or from an on-chip peripheral. Operand breakpoints are taken at once. Prefetch breakpoints travel with their instruction word through a two-entry pipeline model, and are taken only if that word reaches the start of execution without first being flushed.

Two other conditions can also cause entry: the core executing its background instruction, and a catastrophic fault. The block picks one winning cause per cycle. Whether that cause halts the core or raises an ordinary exception depends on a debug enable. The enable is sampled from the breakpoint pin while reset is held and stays fixed until the next reset. While the core is halted the block holds a fetch-inhibit output, and a resume input ends the halt.

All pins are plain control and status signals, one bit of meaning per cycle. No data moves through the block, so it has no valid/ready handshake and no back-pressure. Every input is taken as a single-cycle event in the cycle it is high.

Top module: `dbg_halt_ctrl`

## Requirements
- R1: `dbg_en_o` takes the value of `bkpt_pin_i` at the last clock edge during which `rst_n` is low, and does not change again until the next reset.
- R2: A prefetch (`acc_valid_i`=1, `acc_is_fetch_i`=1) enters the pipeline model with a tag. The tag is set if `bkpt_pin_i` or `periph_bkpt_i` is high in that cycle. When `exec_start_i` pops the oldest word and its tag is set, an instruction breakpoint is acknowledged in that cycle.
- R3: The model holds two words. A prefetch into a full model is discarded. An exec with an empty model acknowledges nothing. `pipe_flush_i` drops every held word and overrides `exec_start_i` in the same cycle. A prefetch in a flush cycle enters the emptied model.
- R4: An operand access (`acc_valid_i`=1, `acc_is_fetch_i`=0) with a breakpoint request is always acknowledged in that same cycle.
- R5: The peripheral breakpoint input acts exactly like the breakpoint pin as a request source.
- R6: With debug enabled and the block not halted, a winning cause sets `halted_o` on the next clock edge. `halt_cause_o` then holds the cause code: 1 fault, 2 operand breakpoint, 3 instruction breakpoint, 4 background instruction. `halt_cause_o` is 0 whenever the block is not halted.
- R7: With debug disabled, a winning cause gives a one-cycle `exc_req_o` pulse on the next clock edge and leaves `halted_o` low. `exc_kind_o` is 0 for a breakpoint, 1 for the background instruction (illegal instruction) and 2 for a fault.
- R8: Among causes arriving in the same cycle, the order of precedence is fault, then operand breakpoint, then instruction breakpoint, then background instruction.
- R9: `fetch_inhibit_o` is high in exactly the cycles where `halted_o` is high.
- R10: `resume_i` while halted clears `halted_o` and `fetch_inhibit_o` on the next clock edge. `resume_i` while not halted has no effect.
- R11: While halted, every entry cause is ignored and the cause code is held.
- R12: Reset clears `halted_o`, `fetch_inhibit_o`, `exc_req_o` and `halt_cause_o`, and empties the pipeline model.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; the debug enable is sampled while it is low |
| bkpt_pin_i | input | 1 | External breakpoint request; also the debug-enable strap during reset |
| periph_bkpt_i | input | 1 | Internal peripheral breakpoint request |
| acc_valid_i | input | 1 | A memory access occurs this cycle |
| acc_is_fetch_i | input | 1 | 1 = instruction prefetch, 0 = operand access |
| exec_start_i | input | 1 | The oldest prefetched word begins execution |
| pipe_flush_i | input | 1 | Discard all prefetched words |
| bgnd_i | input | 1 | Background instruction executed |
| fault_i | input | 1 | Catastrophic fault condition |
| resume_i | input | 1 | Leave the debug halt state |
| dbg_en_o | output | 1 | Latched debug-mode enable |
| halted_o | output | 1 | Core is in the debug halt state |
| fetch_inhibit_o | output | 1 | Core must not fetch over the parallel bus |
| halt_cause_o | output | 3 | Cause code of the current halt, 0 when not halted |
| exc_req_o | output | 1 | One-cycle exception request (debug disabled) |
| exc_kind_o | output | 2 | Exception kind that goes with `exc_req_o` |

## Verification
A wrong tag in the pipeline model stays hidden until its word is popped by an exec. It then shows up as a halt or exception that should not happen, or as one that is missing, on the clock edge after that exec. Stale words left over from a flush, or a wrong occupancy count, become visible only several fetches later. The reference model tracks pipeline occupancy as a queue, and a full-pipeline discard is driven deliberately. An enable or halt register that has lost its state shows at the ports within one cycle, through `dbg_en_o`, `halted_o` or the cause code, and every output is compared on every clock.

// File: rtl/dbg_pkg.sv
package dbg_pkg;

  typedef enum logic [2:0] {
    CAUSE_NONE  = 3'd0,
    CAUSE_FAULT = 3'd1,
    CAUSE_OPND  = 3'd2,
    CAUSE_INSN  = 3'd3,
    CAUSE_BGND  = 3'd4
  } halt_cause_e;

  typedef enum logic [1:0] {
    EXC_BKPT    = 2'd0,
    EXC_ILLEGAL = 2'd1,
    EXC_FAULT   = 2'd2
  } exc_kind_e;

endpackage

// File: rtl/dbg_en_capture.sv
module dbg_en_capture (
  input  logic clk,
  input  logic rst_n,
  input  logic strap_i,
  output logic en_o
);

  // Sampled on every edge while reset is held, frozen afterwards.
  always_ff @(posedge clk) begin
    if (!rst_n) en_o <= strap_i;
  end

endmodule

// File: rtl/dbg_bp_pipe.sv
module dbg_bp_pipe #(
  parameter int DEPTH = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic push_i,
  input  logic push_tag_i,
  input  logic exec_i,
  input  logic flush_i,
  output logic ins_ack_o
);

  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  logic [CW-1:0]    cnt_q, cnt_mid, cnt_d;
  logic [DEPTH-1:0] tag_q, tag_mid, tag_d;

  always_comb begin
    tag_mid   = tag_q;
    cnt_mid   = cnt_q;
    ins_ack_o = 1'b0;
    if (flush_i) begin
      tag_mid = '0;
      cnt_mid = '0;
    end else if (exec_i && cnt_q != '0) begin
      ins_ack_o = tag_q[0];
      tag_mid   = tag_q >> 1;
      cnt_mid   = cnt_q - CW'(1);
    end
    tag_d = tag_mid;
    cnt_d = cnt_mid;
    if (push_i && cnt_mid < FULL) begin
      for (int i = 0; i < DEPTH; i++) begin
        if (cnt_mid == CW'(i)) tag_d[i] = push_tag_i;
      end
      cnt_d = cnt_mid + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      tag_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      tag_q <= tag_d;
    end
  end

endmodule

// File: rtl/dbg_cause_arb.sv
module dbg_cause_arb
  import dbg_pkg::*;
(
  input  logic        fault_i,
  input  logic        opnd_i,
  input  logic        insn_i,
  input  logic        bgnd_i,
  output halt_cause_e cause_o
);

  always_comb begin
    if (fault_i)     cause_o = CAUSE_FAULT;
    else if (opnd_i) cause_o = CAUSE_OPND;
    else if (insn_i) cause_o = CAUSE_INSN;
    else if (bgnd_i) cause_o = CAUSE_BGND;
    else             cause_o = CAUSE_NONE;
  end

endmodule

// File: rtl/dbg_halt_ctrl.sv
module dbg_halt_ctrl
  import dbg_pkg::*;
#(
  parameter int PIPE_DEPTH = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bkpt_pin_i,
  input  logic       periph_bkpt_i,
  input  logic       acc_valid_i,
  input  logic       acc_is_fetch_i,
  input  logic       exec_start_i,
  input  logic       pipe_flush_i,
  input  logic       bgnd_i,
  input  logic       fault_i,
  input  logic       resume_i,
  output logic       dbg_en_o,
  output logic       halted_o,
  output logic       fetch_inhibit_o,
  output logic [2:0] halt_cause_o,
  output logic       exc_req_o,
  output logic [1:0] exc_kind_o
);

  logic        bp_req, opnd_ack, ins_ack, fetch_push;
  halt_cause_e win;
  logic        halted_q, exc_q;
  halt_cause_e cause_q;
  exc_kind_e   kind_q;

  assign bp_req     = bkpt_pin_i | periph_bkpt_i;
  assign opnd_ack   = acc_valid_i & ~acc_is_fetch_i & bp_req;
  assign fetch_push = acc_valid_i & acc_is_fetch_i;

  dbg_en_capture u_en (
    .clk     (clk),
    .rst_n   (rst_n),
    .strap_i (bkpt_pin_i),
    .en_o    (dbg_en_o)
  );

  dbg_bp_pipe #(.DEPTH(PIPE_DEPTH)) u_pipe (
    .clk        (clk),
    .rst_n      (rst_n),
    .push_i     (fetch_push),
    .push_tag_i (bp_req),
    .exec_i     (exec_start_i),
    .flush_i    (pipe_flush_i),
    .ins_ack_o  (ins_ack)
  );

  dbg_cause_arb u_arb (
    .fault_i (fault_i),
    .opnd_i  (opnd_ack),
    .insn_i  (ins_ack),
    .bgnd_i  (bgnd_i),
    .cause_o (win)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      halted_q <= 1'b0;
      cause_q  <= CAUSE_NONE;
      exc_q    <= 1'b0;
      kind_q   <= EXC_BKPT;
    end else begin
      exc_q <= 1'b0;
      if (halted_q) begin
        if (resume_i) begin
          halted_q <= 1'b0;
          cause_q  <= CAUSE_NONE;
        end
      end else if (win != CAUSE_NONE) begin
        if (dbg_en_o) begin
          halted_q <= 1'b1;
          cause_q  <= win;
        end else begin
          exc_q <= 1'b1;
          case (win)
            CAUSE_FAULT: kind_q <= EXC_FAULT;
            CAUSE_BGND:  kind_q <= EXC_ILLEGAL;
            default:     kind_q <= EXC_BKPT;
          endcase
        end
      end
    end
  end

  assign halted_o        = halted_q;
  assign fetch_inhibit_o = halted_q;
  assign halt_cause_o    = cause_q;
  assign exc_req_o       = exc_q;
  assign exc_kind_o      = kind_q;

endmodule

// File: rtl/dbg_halt_ctrl_chk.sv
module dbg_halt_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       fault_i,
  input logic       resume_i,
  input logic       dbg_en_o,
  input logic       halted_o,
  input logic       fetch_inhibit_o,
  input logic [2:0] halt_cause_o,
  input logic       exc_req_o
);

  a_r1_enable_held: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> $stable(dbg_en_o));

  a_r6_cause_when_halted: assert property (@(posedge clk) disable iff (!rst_n)
    halted_o |-> halt_cause_o != 3'd0);

  a_r6_no_cause_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !halted_o |-> halt_cause_o == 3'd0);

  a_r7_exc_only_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    exc_req_o |-> !dbg_en_o && !halted_o);

  a_r8_fault_wins: assert property (@(posedge clk) disable iff (!rst_n)
    !halted_o && fault_i && dbg_en_o |=> halted_o && halt_cause_o == 3'd1);

  a_r10_resume: assert property (@(posedge clk) disable iff (!rst_n)
    halted_o && resume_i |=> !halted_o && !fetch_inhibit_o);

  a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
    halted_o && !resume_i |=> halted_o && $stable(halt_cause_o));

endmodule

bind dbg_halt_ctrl dbg_halt_ctrl_chk u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .fault_i         (fault_i),
  .resume_i        (resume_i),
  .dbg_en_o        (dbg_en_o),
  .halted_o        (halted_o),
  .fetch_inhibit_o (fetch_inhibit_o),
  .halt_cause_o    (halt_cause_o),
  .exc_req_o       (exc_req_o)
);

// File: tb/sim_dbg_halt_ctrl.sv
module sim_dbg_halt_ctrl;

  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bkpt_pin_i = 1'b0, periph_bkpt_i = 1'b0, acc_valid_i = 1'b0, acc_is_fetch_i = 1'b0;
  logic exec_start_i = 1'b0, pipe_flush_i = 1'b0, bgnd_i = 1'b0, fault_i = 1'b0, resume_i = 1'b0;
  logic dbg_en_o, halted_o, fetch_inhibit_o, exc_req_o;
  logic [2:0] halt_cause_o;
  logic [1:0] exc_kind_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference model state
  bit   m_en, m_halted, m_exc;
  int   m_cause, m_kind;
  bit   m_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  dbg_halt_ctrl u0 (.*);

  task automatic model_step();
    bit bp, op_ack, ins_ack;
    int win;
    if (!rst_n) begin
      m_en = bkpt_pin_i; m_halted = 0; m_exc = 0; m_cause = 0; m_kind = 0;
      m_q.delete();
      return;
    end
    bp = bkpt_pin_i | periph_bkpt_i;
    op_ack = acc_valid_i && !acc_is_fetch_i && bp;
    ins_ack = 0;
    if (pipe_flush_i) m_q.delete();
    else if (exec_start_i && m_q.size() > 0) begin
      ins_ack = m_q[0];
      void'(m_q.pop_front());
    end
    if (acc_valid_i && acc_is_fetch_i && m_q.size() < 2) m_q.push_back(bp);
    win = fault_i ? 1 : op_ack ? 2 : ins_ack ? 3 : bgnd_i ? 4 : 0;
    m_exc = 0;
    if (m_halted) begin
      if (resume_i) begin m_halted = 0; m_cause = 0; end
    end else if (win != 0) begin
      if (m_en) begin m_halted = 1; m_cause = win; end
      else begin
        m_exc = 1;
        m_kind = (win == 1) ? 2 : (win == 4) ? 1 : 0;
      end
    end
  endtask

  // One clock: inputs already set; model updates at the edge, outputs compared after it.
  task automatic tick(input string req);
    @(posedge clk);
    model_step();
    #2;
    checks++;
    if (dbg_en_o !== m_en || halted_o !== m_halted || fetch_inhibit_o !== m_halted ||
        int'(halt_cause_o) != m_cause || exc_req_o !== m_exc ||
        (m_exc && int'(exc_kind_o) != m_kind)) begin
      errors++;
      $display("FAIL %s: en/halt/inh/cause/exc/kind = %0d/%0d/%0d/%0d/%0d/%0d expected %0d/%0d/%0d/%0d/%0d/%0d",
               req, dbg_en_o, halted_o, fetch_inhibit_o, halt_cause_o, exc_req_o, exc_kind_o,
               m_en, m_halted, m_halted, m_cause, m_exc, m_kind);
    end
    @(negedge clk);
    periph_bkpt_i = 0; acc_valid_i = 0; acc_is_fetch_i = 0; exec_start_i = 0;
    pipe_flush_i = 0; bgnd_i = 0; fault_i = 0; resume_i = 0;
    if (rst_n) bkpt_pin_i = 0;
  endtask

  task automatic fetch(input bit tag, input string req);
    acc_valid_i = 1; acc_is_fetch_i = 1; periph_bkpt_i = tag; tick(req);
  endtask

  task automatic do_reset(input bit strap);
    rst_n = 0; bkpt_pin_i = strap;
    tick("R12"); tick("R1");
    @(negedge clk);
    rst_n = 1; bkpt_pin_i = 0;
    tick("R1"); tick("R12");
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not end, actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    // debug enabled
    do_reset(1'b1);
    bkpt_pin_i = 1; tick("R1"); tick("R1");
    // operand breakpoint via pin
    acc_valid_i = 1; bkpt_pin_i = 1; tick("R4"); tick("R9");
    // ignored while halted
    fault_i = 1; tick("R11");
    acc_valid_i = 1; periph_bkpt_i = 1; bgnd_i = 1; tick("R11");
    resume_i = 1; tick("R10"); tick("R10");
    resume_i = 1; tick("R10");
    // instruction breakpoint via peripheral source
    fetch(1, "R5"); exec_start_i = 1; tick("R2"); tick("R2");
    resume_i = 1; tick("R10");
    // tagged word flushed
    fetch(1, "R3"); pipe_flush_i = 1; tick("R3");
    exec_start_i = 1; tick("R3"); tick("R3");
    // flush with exec same cycle, fetch in flush cycle enters empty pipe
    fetch(1, "R3"); pipe_flush_i = 1; exec_start_i = 1; acc_valid_i = 1; acc_is_fetch_i = 1; tick("R3");
    exec_start_i = 1; tick("R3"); tick("R3");
    // order: plain then tagged
    fetch(0, "R2"); fetch(1, "R2");
    exec_start_i = 1; tick("R2");
    exec_start_i = 1; tick("R2"); tick("R2");
    resume_i = 1; tick("R10");
    // full pipe discards third fetch
    fetch(0, "R3"); fetch(0, "R3"); fetch(1, "R3");
    exec_start_i = 1; tick("R3"); exec_start_i = 1; tick("R3");
    exec_start_i = 1; tick("R3"); tick("R3");
    // exec with pop and push in same cycle
    fetch(0, "R2"); exec_start_i = 1; acc_valid_i = 1; acc_is_fetch_i = 1; bkpt_pin_i = 1; tick("R2");
    exec_start_i = 1; tick("R2"); tick("R2");
    resume_i = 1; tick("R10");
    // background and fault causes
    bgnd_i = 1; tick("R6"); resume_i = 1; tick("R10");
    fault_i = 1; tick("R6"); resume_i = 1; tick("R10");
    // priority
    fetch(1, "R8");
    fault_i = 1; bgnd_i = 1; exec_start_i = 1; acc_valid_i = 1; periph_bkpt_i = 1; tick("R8");
    resume_i = 1; tick("R10");
    fetch(1, "R8");
    bgnd_i = 1; exec_start_i = 1; acc_valid_i = 1; periph_bkpt_i = 1; tick("R8");
    resume_i = 1; tick("R10");
    fetch(1, "R8");
    bgnd_i = 1; exec_start_i = 1; tick("R8");
    resume_i = 1; tick("R10");
    // operand access without request
    acc_valid_i = 1; tick("R4"); tick("R4");
    // debug disabled
    do_reset(1'b0);
    bkpt_pin_i = 1; tick("R1");
    acc_valid_i = 1; bkpt_pin_i = 1; tick("R7"); tick("R7");
    bgnd_i = 1; tick("R7"); tick("R7");
    fault_i = 1; tick("R7");
    fault_i = 1; tick("R7"); tick("R7");
    fetch(1, "R7"); exec_start_i = 1; tick("R7"); tick("R7");
    fetch(1, "R7"); pipe_flush_i = 1; tick("R7"); exec_start_i = 1; tick("R7");
    fault_i = 1; bgnd_i = 1; tick("R8");
    resume_i = 1; tick("R10");
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule